// File: doc/BRIEF.md
# Enhanced Input Capture Timer

This block is a timer peripheral built around a 16-bit free-running counter that advances once per prescaled tick of the bus clock. Eight channels share the counter. Each one is set on its own to capture the count when its pin shows a chosen edge, or to compare the count against a stored value and change its pin when they match. Every channel, counter overflow and the modulus counter has its own interrupt flag. Each flag is cleared by writing one to it and can be routed to an interrupt output.

The lower four channels are the buffered ones. Each has a holding register behind its capture register, and each has a programmable delay filter on its input that swallows short glitches. A separate 16-bit modulus down-counter with its own divider gives a periodic event. At that event it can copy the four capture registers into their holding registers. As an alternative, each new capture can push the previous value into the holding register, so that two successive captures are kept.

Software drives the block through a single-cycle register port: writes take effect at the clock edge and reads are combinational. Pins are synchronised by two flops before they reach the filters and the edge detectors.

Top module: `ect_timer`

## Requirements
- R1: Control register 0 holds run in bit 0 and prescale p (0..7) in bits 3:1. While run is set, the counter (register 9, readable and writable) goes up by one every 2^p clocks, with the first step 2^p clocks after run is set. While run is clear, the counter holds.
- R2: Bit i of register 1 puts channel i in compare mode (1) or capture mode (0). A channel in compare mode ignores edges on its pin.
- R3: In capture mode, the 2-bit field at bits 2i+1:2i of register 3 selects the edges: 00 none, 01 rising, 10 falling, 11 both. A selected edge copies the counter into channel register 16+i and sets flag bit i.
- R4: In compare mode, flag i is set when the counter steps onto the value in register 16+i. The pin then follows the 2-bit action at bits 2i+1:2i of register 2: 01 toggle, 10 clear, 11 set. Action 00 releases the pin, and pin_oe[i] is high only for a compare channel with a non-zero action.
- R5: Channels 0..3 pass through a filter selected by bits 2i+1:2i of register 8: 0 bypass, 1/2/3 need the input to be steady for 4/16/64 clocks. A pulse shorter than the delay never causes a capture.
- R6: Flag bit 8 is set when the counter steps from FFFF to 0000.
- R7: Register 6 holds run in bit 0 and divider d in bits 4:1. While run is set, the modulus counter (read at register 10) goes down once every d+1 clocks. A step from zero reloads it from register 7 and sets flag bit 9. A write to register 7 also loads the counter.
- R8: When bit 5 of register 6 is set, each modulus reload copies channel registers 0..3 into holding registers 24..27.
- R9: When bit 6 of register 6 is set, a capture on channels 0..3 moves the previous capture value into that channel's holding register.
- R10: Flags in register 4 are cleared by writing one to them. An event in the same cycle as the clear leaves the flag set.
- R11: irq equals the flags ANDed with the enable mask in register 5.
- R12: After reset all registers, flags, pin outputs and pin enables are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register address |
| bus_we | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pin_in | input | 8 | Timer pins, input side |
| pin_out | output | 8 | Timer pins, driven level |
| pin_oe | output | 8 | Timer pins, drive enable |
| irq | output | 10 | Enabled flags: channels 7:0, overflow 8, modulus 9 |

## Verification
The assertions assume that pins are steady between bench steps, so that the synchroniser and the filter see clean levels. They also assume that software writes the counter and the flag register only through the register port, one write per cycle. The stimulus changes pins and writes registers only on falling clock edges. It leaves several idle cycles after every pin change, and it stops the counter before it samples any captured value, so that each expected value is exact. Prescaler and modulus checks stop the count at a chosen edge and compare the counter against a value worked out from the tick phase.

// File: rtl/ect_pkg.sv
package ect_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ACT_OFF    = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } oc_act_e;

  localparam logic [ADDR_W-1:0] A_TCTL  = 5'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 5'd1;
  localparam logic [ADDR_W-1:0] A_ACT   = 5'd2;
  localparam logic [ADDR_W-1:0] A_EDGE  = 5'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS = 5'd4;
  localparam logic [ADDR_W-1:0] A_IEN   = 5'd5;
  localparam logic [ADDR_W-1:0] A_MCTL  = 5'd6;
  localparam logic [ADDR_W-1:0] A_MLOAD = 5'd7;
  localparam logic [ADDR_W-1:0] A_FILT  = 5'd8;
  localparam logic [ADDR_W-1:0] A_TCNT  = 5'd9;
  localparam logic [ADDR_W-1:0] A_MCNT  = 5'd10;
  localparam logic [ADDR_W-1:0] A_CH0   = 5'd16;
  localparam logic [ADDR_W-1:0] A_HOLD0 = 5'd24;
endpackage

// File: rtl/ect_filter.sv
module ect_filter #(
  parameter int FLT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] sel,
  output logic       dout
);
  logic [FLT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic [FLT_W:0]   dly;

  always_comb begin
    dly   = (sel == 2'd0) ? '0 : ((FLT_W+1)'(1) << {sel, 1'b0});
    out_d = out_q;
    cnt_d = cnt_q;
    if (din == out_q) begin
      cnt_d = '0;
    end else if (dly == '0 || {1'b0, cnt_q} == dly - 1'b1) begin
      out_d = din;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign dout = out_q;

  // R5: with a delay selected, a steady input never moves the output
  assert_filter_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != 2'd0 && din == out_q) |=> $stable(out_q));
endmodule

// File: rtl/ect_channel.sv
module ect_channel import ect_pkg::*; #(
  parameter int CW       = 16,
  parameter bit HAS_HOLD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_f,
  input  logic          is_oc,
  input  logic [1:0]    edge_sel,
  input  logic [1:0]    act,
  input  logic          tick,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] cnt_nx,
  input  logic          wr_en,
  input  logic [CW-1:0] wdata,
  input  logic          latch_hold,
  input  logic          queue_mode,
  output logic [CW-1:0] chreg,
  output logic [CW-1:0] hold,
  output logic          event_o,
  output logic          pin_o
);
  logic          prev_q;
  logic [CW-1:0] ch_q, ch_d;
  logic          pin_q, pin_d;
  logic          rise, fall, cap_ev, cmp_ev;

  assign rise   = pin_f & ~prev_q;
  assign fall   = ~pin_f & prev_q;
  assign cap_ev = !is_oc && ((edge_sel[0] && rise) || (edge_sel[1] && fall));
  assign cmp_ev = is_oc && tick && (cnt_nx == ch_q);
  assign event_o = cap_ev | cmp_ev;

  always_comb begin
    ch_d  = ch_q;
    pin_d = pin_q;
    if (cap_ev)     ch_d = cnt_q;
    else if (wr_en) ch_d = wdata;
    if (cmp_ev) begin
      unique case (oc_act_e'(act))
        ACT_TOGGLE: pin_d = ~pin_q;
        ACT_CLEAR:  pin_d = 1'b0;
        ACT_SET:    pin_d = 1'b1;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      ch_q   <= '0;
      pin_q  <= 1'b0;
    end else begin
      prev_q <= pin_f;
      ch_q   <= ch_d;
      pin_q  <= pin_d;
    end
  end

  assign chreg = ch_q;
  assign pin_o = pin_q;

  generate
    if (HAS_HOLD) begin : g_hold
      logic [CW-1:0] hold_q, hold_d;
      always_comb begin
        hold_d = hold_q;
        if ((cap_ev && queue_mode) || latch_hold) hold_d = ch_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
      end
      assign hold = hold_q;

      // R9: queued capture keeps the previous value
      assert_queue_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ev && queue_mode) |=> (hold_q == $past(ch_q)));
    end else begin : g_nohold
      logic unused_hold;
      assign unused_hold = latch_hold ^ queue_mode;
      assign hold = '0;
    end
  endgenerate

  // R3: a capture stores the count seen at the edge
  assert_capture_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (ch_q == $past(cnt_q)));
  // R4: set and clear actions reach the pin on the match
  assert_compare_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ev && act == ACT_SET) |=> pin_q);
  assert_compare_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ev && act == ACT_CLEAR) |=> !pin_q);
  // R2: a compare channel never captures
  assert_oc_no_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_oc && !wr_en) |=> $stable(ch_q));
endmodule

// File: rtl/ect_modcnt.sv
module ect_modcnt #(
  parameter int CW     = 16,
  parameter int MDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [MDIV_W-1:0] div,
  input  logic [CW-1:0]     load_val,
  input  logic              load_wr,
  output logic [CW-1:0]     mcnt,
  output logic              underflow
);
  logic [MDIV_W-1:0] pre_q, pre_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              mtick;

  assign mtick     = run && (pre_q == div);
  assign underflow = mtick && (cnt_q == '0);

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (load_wr) begin
      pre_d = '0;
      cnt_d = load_val;
    end else begin
      if (!run || mtick) pre_d = '0;
      else               pre_d = pre_q + 1'b1;
      if (mtick) cnt_d = underflow ? load_val : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign mcnt = cnt_q;

  // R7: an underflow reloads the programmed value
  assert_mod_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !load_wr) |=> (cnt_q == $past(load_val)));
  // R7: a stopped counter holds
  assert_mod_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/ect_timer.sv
module ect_timer import ect_pkg::*; #(
  parameter int NCH    = 8,
  parameter int NBUF   = 4,
  parameter int CW     = 16,
  parameter int PS_W   = 3,
  parameter int MDIV_W = 4,
  parameter int FLT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CW-1:0]     bus_wdata,
  output logic [CW-1:0]     bus_rdata,
  input  logic [NCH-1:0]    pin_in,
  output logic [NCH-1:0]    pin_out,
  output logic [NCH-1:0]    pin_oe,
  output logic [NCH+1:0]    irq
);
  localparam int PRE_W = (1 << PS_W) - 1;
  localparam int NFLG  = NCH + 2;
  localparam int F_OVF = NCH;
  localparam int F_MOD = NCH + 1;

  function automatic logic wr_hit(input logic [ADDR_W-1:0] a);
    return bus_we && (bus_addr == a);
  endfunction

  // configuration registers
  logic              run_q, mrun_q, mlatch_q, mqueue_q;
  logic [PS_W-1:0]   ps_q;
  logic [MDIV_W-1:0] mdiv_q;
  logic [NCH-1:0]    mode_q;
  logic [2*NCH-1:0]  act_q, edge_q;
  logic [NFLG-1:0]   ien_q;
  logic [CW-1:0]     mload_q;
  logic [2*NBUF-1:0] filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; ps_q <= '0; mode_q <= '0; act_q <= '0; edge_q <= '0;
      ien_q <= '0; mrun_q <= 1'b0; mdiv_q <= '0; mlatch_q <= 1'b0;
      mqueue_q <= 1'b0; mload_q <= '0; filt_q <= '0;
    end else begin
      if (wr_hit(A_TCTL))  {ps_q, run_q} <= bus_wdata[PS_W:0];
      if (wr_hit(A_MODE))  mode_q <= bus_wdata[NCH-1:0];
      if (wr_hit(A_ACT))   act_q  <= bus_wdata[2*NCH-1:0];
      if (wr_hit(A_EDGE))  edge_q <= bus_wdata[2*NCH-1:0];
      if (wr_hit(A_IEN))   ien_q  <= bus_wdata[NFLG-1:0];
      if (wr_hit(A_MCTL))  {mqueue_q, mlatch_q, mdiv_q, mrun_q} <= bus_wdata[MDIV_W+2:0];
      if (wr_hit(A_MLOAD)) mload_q <= bus_wdata;
      if (wr_hit(A_FILT))  filt_q <= bus_wdata[2*NBUF-1:0];
    end
  end

  // main counter and prescaler
  logic [PRE_W-1:0] pcnt_q, pcnt_d, mask;
  logic [CW-1:0]    tcnt_q, tcnt_d, cnt_nx;
  logic             tick, tcnt_wr, tick_eff, ovf_ev;

  assign mask     = ~({PRE_W{1'b1}} << ps_q);
  assign tick     = run_q && ((pcnt_q & mask) == mask);
  assign tcnt_wr  = wr_hit(A_TCNT);
  assign tick_eff = tick && !tcnt_wr;
  assign cnt_nx   = tcnt_q + 1'b1;
  assign ovf_ev   = tick_eff && (&tcnt_q);

  always_comb begin
    pcnt_d = run_q ? pcnt_q + 1'b1 : '0;
    if (tcnt_wr)       tcnt_d = bus_wdata;
    else if (tick)     tcnt_d = cnt_nx;
    else               tcnt_d = tcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      tcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      tcnt_q <= tcnt_d;
    end
  end

  // modulus counter
  logic [CW-1:0] mcnt, mload_src;
  logic          mod_uf;
  assign mload_src = wr_hit(A_MLOAD) ? bus_wdata : mload_q;

  ect_modcnt #(.CW(CW), .MDIV_W(MDIV_W)) u_mod (
    .clk(clk), .rst_n(rst_n), .run(mrun_q), .div(mdiv_q),
    .load_val(mload_src), .load_wr(wr_hit(A_MLOAD)),
    .mcnt(mcnt), .underflow(mod_uf));

  // pin synchroniser
  logic [NCH-1:0] sync1_q, sync2_q, pin_f, ch_ev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  logic [CW-1:0] chreg [NCH];
  logic [CW-1:0] hold  [NCH];

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      if (i < NBUF) begin : g_flt
        ect_filter #(.FLT_W(FLT_W)) u_flt (
          .clk(clk), .rst_n(rst_n), .din(sync2_q[i]),
          .sel(filt_q[2*i+1:2*i]), .dout(pin_f[i]));
      end else begin : g_raw
        assign pin_f[i] = sync2_q[i];
      end

      ect_channel #(.CW(CW), .HAS_HOLD(i < NBUF)) u_ch (
        .clk(clk), .rst_n(rst_n), .pin_f(pin_f[i]), .is_oc(mode_q[i]),
        .edge_sel(edge_q[2*i+1:2*i]), .act(act_q[2*i+1:2*i]),
        .tick(tick_eff), .cnt_q(tcnt_q), .cnt_nx(cnt_nx),
        .wr_en(wr_hit(A_CH0 + ADDR_W'(i))), .wdata(bus_wdata),
        .latch_hold(mod_uf && mlatch_q), .queue_mode(mqueue_q),
        .chreg(chreg[i]), .hold(hold[i]), .event_o(ch_ev[i]),
        .pin_o(pin_out[i]));

      assign pin_oe[i] = mode_q[i] && (act_q[2*i+1:2*i] != ACT_OFF);
    end
  endgenerate

  // interrupt flags
  logic [NFLG-1:0] flag_q, flag_d, flag_clr, ev_vec;
  assign ev_vec   = {mod_uf, ovf_ev, ch_ev};
  assign flag_clr = wr_hit(A_FLAGS) ? bus_wdata[NFLG-1:0] : '0;
  assign flag_d   = (flag_q & ~flag_clr) | ev_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign irq = flag_q & ien_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_TCTL:  bus_rdata = CW'({ps_q, run_q});
      A_MODE:  bus_rdata = CW'(mode_q);
      A_ACT:   bus_rdata = CW'(act_q);
      A_EDGE:  bus_rdata = CW'(edge_q);
      A_FLAGS: bus_rdata = CW'(flag_q);
      A_IEN:   bus_rdata = CW'(ien_q);
      A_MCTL:  bus_rdata = CW'({mqueue_q, mlatch_q, mdiv_q, mrun_q});
      A_MLOAD: bus_rdata = mload_q;
      A_FILT:  bus_rdata = CW'(filt_q);
      A_TCNT:  bus_rdata = tcnt_q;
      A_MCNT:  bus_rdata = mcnt;
      default: begin
        for (int k = 0; k < NCH; k++) begin
          if (bus_addr == A_CH0 + ADDR_W'(k))   bus_rdata = chreg[k];
          if (bus_addr == A_HOLD0 + ADDR_W'(k)) bus_rdata = hold[k];
        end
      end
    endcase
  end

  // R1: each tick moves the counter by one, a stopped counter holds
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_eff |=> (tcnt_q == $past(tcnt_q) + CW'(1)));
  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !tcnt_wr) |=> $stable(tcnt_q));
  // R6: wrap sets the overflow flag
  assert_overflow_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> flag_q[F_OVF]);
  // R7: modulus underflow raises its flag
  assert_mod_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mod_uf |=> flag_q[F_MOD]);
  // R10: an event beats a simultaneous clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_vec) |=> ((flag_q & $past(ev_vec)) == $past(ev_vec)));
endmodule

// File: tb/tb_ect_timer.sv
`timescale 1ns/1ps
module tb_ect_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [7:0]  pin_in, pin_out, pin_oe;
  logic [9:0]  irq;

  always #2.5 clk = ~clk;

  ect_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  // scoreboard
  string       tag_q[$];
  logic [15:0] exp_q[$];
  logic [15:0] act_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic expect_val(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tag_q.push_back(tag);
    exp_q.push_back(exp);
    act_q.push_back(act);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        string t;
        logic [15:0] a, e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        a = act_q.pop_front();
        n_cmp++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, a, e);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [15:0] e);
    @(negedge clk);
    bus_addr = a;
    #1;
    expect_val(tag, bus_rdata, e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_burst(input int n);
    wr(5'd0, 16'h0001);
    idle(n);
    wr(5'd0, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
    idle(5);
    rst_n = 1'b1;
    // R12 reset state
    rd_chk("R12 flags", 5'd4, 16'h0000);
    rd_chk("R12 count", 5'd9, 16'h0000);
    rd_chk("R12 modcount", 5'd10, 16'h0000);
    expect_val("R12 pin_oe", {8'h00, pin_oe}, 16'h0000);
    expect_val("R12 pin_out", {8'h00, pin_out}, 16'h0000);
    expect_val("R12 irq", {6'h00, irq}, 16'h0000);

    // ch0 rise, ch1 both, ch5 rise, ch7 fall
    wr(5'd3, 16'h840D);
    wr(5'd9, 16'h1234);
    pin_in[5] = 1'b1; idle(8);
    rd_chk("R3 rise capture", 5'd21, 16'h1234);
    rd_chk("R3 rise flag", 5'd4, 16'h0020);
    wr(5'd4, 16'h0020);
    rd_chk("R10 w1c", 5'd4, 16'h0000);
    wr(5'd9, 16'h2222);
    pin_in[5] = 1'b0; idle(8);
    rd_chk("R3 fall ignored flag", 5'd4, 16'h0000);
    rd_chk("R3 fall ignored value", 5'd21, 16'h1234);
    pin_in[7] = 1'b1; idle(8);
    rd_chk("R3 rise ignored on fall-only", 5'd4, 16'h0000);
    wr(5'd9, 16'h4444);
    pin_in[7] = 1'b0; idle(8);
    rd_chk("R3 fall flag", 5'd4, 16'h0080);
    rd_chk("R3 fall capture", 5'd23, 16'h4444);

    // R11 interrupt masking
    wr(5'd5, 16'h0080); idle(1);
    expect_val("R11 irq enabled", {6'h00, irq}, 16'h0080);
    wr(5'd5, 16'h0001); idle(1);
    expect_val("R11 irq masked", {6'h00, irq}, 16'h0000);
    wr(5'd4, 16'h03FF);

    // R5 glitch filter on ch1, 4 clocks
    wr(5'd8, 16'h0004);
    wr(5'd9, 16'h0555);
    pin_in[1] = 1'b1; idle(2); pin_in[1] = 1'b0; idle(12);
    rd_chk("R5 short pulse rejected", 5'd4, 16'h0000);
    pin_in[1] = 1'b1; idle(12);
    rd_chk("R5 long pulse flag", 5'd4, 16'h0002);
    rd_chk("R5 long pulse capture", 5'd17, 16'h0555);
    wr(5'd9, 16'h0666);
    pin_in[1] = 1'b0; idle(12);
    rd_chk("R3 both edges", 5'd17, 16'h0666);
    wr(5'd4, 16'h03FF);

    // R9 queued capture on ch0
    wr(5'd6, 16'h0040);
    wr(5'd9, 16'h0A0A);
    pin_in[0] = 1'b1; idle(8);
    wr(5'd9, 16'h0B0B);
    pin_in[0] = 1'b0; idle(8);
    pin_in[0] = 1'b1; idle(8);
    rd_chk("R9 newest", 5'd16, 16'h0B0B);
    rd_chk("R9 previous", 5'd24, 16'h0A0A);
    wr(5'd6, 16'h0000);

    // R1 prescale 4: write at E0, stop at E40 -> 10 steps
    wr(5'd9, 16'h0000);
    wr(5'd0, 16'h0005);
    idle(38);
    wr(5'd0, 16'h0000);
    rd_chk("R1 prescaled count", 5'd9, 16'd10);
    idle(4);
    rd_chk("R1 stopped hold", 5'd9, 16'd10);

    // R6 overflow
    wr(5'd4, 16'h03FF);
    wr(5'd9, 16'hFFFE);
    run_burst(5);
    rd_chk("R6 overflow flag", 5'd4, 16'h0100);
    wr(5'd4, 16'h03FF);

    // R4 compare on ch4
    wr(5'd1, 16'h0010);
    wr(5'd2, 16'h0300);
    idle(1);
    expect_val("R4 oe with action", {8'h00, pin_oe}, 16'h0010);
    expect_val("R4 pin before match", {8'h00, pin_out}, 16'h0000);
    wr(5'd20, 16'h0104);
    wr(5'd9, 16'h0100);
    run_burst(10);
    expect_val("R4 set action", {8'h00, pin_out}, 16'h0010);
    rd_chk("R4 compare flag", 5'd4, 16'h0010);
    wr(5'd2, 16'h0200);
    wr(5'd9, 16'h0100);
    run_burst(10);
    expect_val("R4 clear action", {8'h00, pin_out}, 16'h0000);
    wr(5'd2, 16'h0100);
    wr(5'd9, 16'h0100);
    run_burst(10);
    expect_val("R4 toggle action", {8'h00, pin_out}, 16'h0010);
    wr(5'd2, 16'h0000);
    idle(1);
    expect_val("R4 released pin", {8'h00, pin_oe}, 16'h0000);

    // R2 compare channel ignores its pin (ch5)
    wr(5'd1, 16'h0030);
    wr(5'd4, 16'h03FF);
    pin_in[5] = 1'b1; idle(8);
    rd_chk("R2 no capture flag", 5'd4, 16'h0000);
    rd_chk("R2 no capture value", 5'd21, 16'h1234);

    // R7 and R8 modulus counter
    wr(5'd7, 16'h0003);
    wr(5'd6, 16'h0023);
    idle(18);
    wr(5'd6, 16'h0000);
    rd_chk("R7 modulus count", 5'd10, 16'h0001);
    rd_chk("R7 modulus flag", 5'd4, 16'h0200);
    rd_chk("R8 latched hold", 5'd24, 16'h0B0B);

    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule